// File: doc/BRIEF.md
# Cache-Line Store Backup Buffer

This block keeps an ordered list of (address, data) pairs for "allocate-and-store" writes that land in cacheable memory. While a pair is held, the matching line can later be invalidated. When that happens, the oldest held store to that line is replayed to memory and then dropped. The buffer can also be emptied in one step, and in that case nothing is written.

The block has three request ports and one memory write port. The push port records a write. The caller's cacheability decision arrives on a separate input. The invalidate port carries a line address. It is a level request: the caller holds it until `inv_done_o` rises. On a hit, the saved store goes out on the memory port under a valid/ready handshake. The discard port clears the buffer. Invalidate and discard requests are acted on only while no replay is pending. A discard takes precedence over an invalidate or a push in the same cycle.

Top module: `store_backup_buf`

## Requirements
- R1: A push is recorded only when `push_cacheable_i` is high in the push cycle. Otherwise the push has no effect, and a later invalidate of that line misses.
- R2: Entries are kept in arrival order. Each new entry goes to the tail.
- R3: An invalidate matches an entry when address bits [AW-1:5] are equal, so a line is 32 bytes. Bits [4:0] are ignored, and a difference in bit 5 or above means no match.
- R4: On a match, exactly one store is issued. It carries the entry's saved full address on `mem_addr_o` and the saved data on `mem_data_o`. The entry is then removed.
- R5: Only the oldest matching entry is serviced per invalidate. Younger matching entries stay and are serviced by later invalidates, oldest first.
- R6: A discard removes every entry and issues no memory write. Afterwards the buffer is empty and accepts DEPTH new entries.
- R7: `mem_valid_o`, `mem_addr_o` and `mem_data_o` hold steady until `mem_ready_i` is high. `inv_done_o` with `inv_hit_o` = 1 is asserted only in the cycle the store is accepted.
- R8: A cacheable push while DEPTH entries are held is dropped. `overflow_o` is then high for one cycle, the cycle after that push.
- R9: An invalidate that matches nothing raises `inv_done_o` with `inv_hit_o` = 0 in the same cycle it is presented, and issues no write.
- R10: Removing an entry from the middle shifts the younger entries toward the head in the same cycle, so the relative order of the rest is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_valid_i | input | 1 | Record-write request |
| push_addr_i | input | AW | Full byte address of the write |
| push_data_i | input | DW | Write data |
| push_cacheable_i | input | 1 | Address is cacheable |
| overflow_o | output | 1 | Previous cycle's push was dropped because the buffer was full |
| inv_valid_i | input | 1 | Line invalidate request, held until done |
| inv_addr_i | input | AW | Address selecting the line |
| inv_done_o | output | 1 | Invalidate complete |
| inv_hit_o | output | 1 | With done: an entry was replayed |
| discard_i | input | 1 | Drop all entries without writing |
| mem_valid_o | output | 1 | Replay store valid |
| mem_ready_i | input | 1 | Memory accepts the store |
| mem_addr_o | output | AW | Replay store address |
| mem_data_o | output | DW | Replay store data |

## Verification
The bench builds the block with DEPTH = 4 and 32-bit address and data. A depth this small lets a few pushes reach the full boundary, both after reset and right after a discard. That exercises the overflow drop and checks that the tail has moved back to the head. With only four slots, removal from the head, the middle and the tail can all be provoked with short sequences. Several lines share and differ in bit 5, which exercises the line-match boundary.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
  localparam int unsigned LINE_LSB = 5;
  typedef enum logic {ST_IDLE, ST_REPLAY} sbb_state_e;
endpackage

// File: rtl/sbb_store.sv
module sbb_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  localparam int unsigned IDXW = $clog2(DEPTH),
  localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            push_i,
  input  logic [AW-1:0]   push_addr_i,
  input  logic [DW-1:0]   push_data_i,
  input  logic            pop_i,
  input  logic [IDXW-1:0] pop_idx_i,
  output logic [AW-1:0]   addr_o [DEPTH],
  output logic [DW-1:0]   data_o [DEPTH],
  output logic            valid_o [DEPTH],
  output logic            full_o
);
  logic [CNTW-1:0] cnt_q, cnt_n, cnt_mid;
  logic [AW-1:0]   addr_q [DEPTH];
  logic [AW-1:0]   addr_n [DEPTH];
  logic [DW-1:0]   data_q [DEPTH];
  logic [DW-1:0]   data_n [DEPTH];

  always_comb begin
    cnt_mid = cnt_q;
    for (int i = 0; i < DEPTH; i++) begin
      addr_n[i] = addr_q[i];
      data_n[i] = data_q[i];
    end
    if (pop_i) begin
      // compact: younger entries move one slot toward the head
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IDXW'(i) >= pop_idx_i) begin
          addr_n[i] = addr_q[i+1];
          data_n[i] = data_q[i+1];
        end
      end
      cnt_mid = cnt_q - CNTW'(1);
    end
    cnt_n = cnt_mid;
    if (push_i && (cnt_mid < CNTW'(DEPTH))) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CNTW'(i) == cnt_mid) begin
          addr_n[i] = push_addr_i;
          data_n[i] = push_data_i;
        end
      end
      cnt_n = cnt_mid + CNTW'(1);
    end
    if (clear_i) cnt_n = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_n;
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      addr_q[i] <= addr_n[i];
      data_q[i] <= data_n[i];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_out
    assign addr_o[g]  = addr_q[g];
    assign data_o[g]  = data_q[g];
    assign valid_o[g] = (CNTW'(g) < cnt_q);
  end

  assign full_o = (cnt_q == CNTW'(DEPTH));

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNTW'(DEPTH)); // R8
  AST_CLEAR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0)); // R6
  AST_POP_SHRINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !clear_i) |=> (cnt_q == $past(cnt_q) - CNTW'(1))); // R10
endmodule

// File: rtl/sbb_match.sv
module sbb_match #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 32,
  parameter int unsigned LSB   = 5,
  localparam int unsigned IDXW = $clog2(DEPTH)
) (
  input  logic [AW-1:0]   addr_i [DEPTH],
  input  logic            valid_i [DEPTH],
  input  logic [AW-1:0]   key_i,
  output logic            hit_o,
  output logic [IDXW-1:0] idx_o
);
  logic [DEPTH-1:0] eq;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign eq[g] = valid_i[g] && (addr_i[g][AW-1:LSB] == key_i[AW-1:LSB]);
  end

  // lowest slot is the oldest entry
  always_comb begin
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (eq[i]) idx_o = IDXW'(i);
    end
  end

  assign hit_o = |eq;
endmodule

// File: rtl/store_backup_buf.sv
module store_backup_buf
  import sbb_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  localparam int unsigned IDXW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_valid_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          push_cacheable_i,
  output logic          overflow_o,
  input  logic          inv_valid_i,
  input  logic [AW-1:0] inv_addr_i,
  output logic          inv_done_o,
  output logic          inv_hit_o,
  input  logic          discard_i,
  output logic          mem_valid_o,
  input  logic          mem_ready_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o
);
  sbb_state_e      state_q, state_n;
  logic [IDXW-1:0] rep_q, rep_n;
  logic [AW-1:0]   e_addr [DEPTH];
  logic [DW-1:0]   e_data [DEPTH];
  logic            e_vld  [DEPTH];
  logic            full, clear, push_ok, pop;
  logic            m_hit;
  logic [IDXW-1:0] m_idx;
  logic            ovf_q;

  sbb_match #(.DEPTH(DEPTH), .AW(AW), .LSB(LINE_LSB)) u_match (
    .addr_i (e_addr),
    .valid_i(e_vld),
    .key_i  (inv_addr_i),
    .hit_o  (m_hit),
    .idx_o  (m_idx)
  );

  sbb_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear),
    .push_i     (push_ok),
    .push_addr_i(push_addr_i),
    .push_data_i(push_data_i),
    .pop_i      (pop),
    .pop_idx_i  (rep_q),
    .addr_o     (e_addr),
    .data_o     (e_data),
    .valid_o    (e_vld),
    .full_o     (full)
  );

  always_comb begin
    state_n    = state_q;
    rep_n      = rep_q;
    clear      = 1'b0;
    pop        = 1'b0;
    inv_done_o = 1'b0;
    inv_hit_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (discard_i) begin
          clear = 1'b1;
        end else if (inv_valid_i) begin
          if (m_hit) begin
            state_n = ST_REPLAY;
            rep_n   = m_idx;
          end else begin
            inv_done_o = 1'b1;
          end
        end
      end
      ST_REPLAY: begin
        if (mem_ready_i) begin
          pop        = 1'b1;
          inv_done_o = 1'b1;
          inv_hit_o  = 1'b1;
          state_n    = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // full is judged before any same-cycle removal
  assign push_ok = push_valid_i && push_cacheable_i && !full && !clear;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rep_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      rep_q   <= rep_n;
      ovf_q   <= push_valid_i && push_cacheable_i && full && !clear;
    end
  end

  assign overflow_o  = ovf_q;
  assign mem_valid_o = (state_q == ST_REPLAY);
  assign mem_addr_o  = e_addr[rep_q];
  assign mem_data_o  = e_data[rep_q];

  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o))); // R7
  AST_HIT_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_done_o && inv_hit_o) |-> (mem_valid_o && mem_ready_i)); // R7
  AST_MISS_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_done_o && !inv_hit_o) |-> !mem_valid_o); // R9
  AST_OVF_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> $past(full)); // R8
  AST_REPLAY_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_valid_o) |-> e_vld[rep_q]); // R4
endmodule

// File: tb/store_backup_buf_tb_top.sv
`timescale 1ns/1ps
module store_backup_buf_tb_top;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push_valid = 0, push_cache = 0, inv_valid = 0, discard = 0, mem_ready = 0;
  logic [AW-1:0] push_addr = '0, inv_addr = '0;
  logic [DW-1:0] push_data = '0;
  logic overflow, inv_done, inv_hit, mem_valid;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  int checks = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  store_backup_buf #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .push_valid_i(push_valid), .push_addr_i(push_addr), .push_data_i(push_data),
    .push_cacheable_i(push_cache), .overflow_o(overflow),
    .inv_valid_i(inv_valid), .inv_addr_i(inv_addr), .inv_done_o(inv_done), .inv_hit_o(inv_hit),
    .discard_i(discard),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_addr_o(mem_addr), .mem_data_o(mem_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_push(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit c, input bit exp_ovf, input string req);
    @(negedge clk);
    push_valid = 1; push_addr = a; push_data = d; push_cache = c;
    @(negedge clk);
    push_valid = 0; push_cache = 0;
    #1 chk(overflow == exp_ovf, req, overflow, exp_ovf);
  endtask

  task automatic do_inv(input logic [AW-1:0] a, input bit exp_hit, input logic [AW-1:0] ea,
                        input logic [DW-1:0] ed, input int delay, input string req);
    @(negedge clk);
    inv_valid = 1; inv_addr = a;
    #1;
    if (!exp_hit) begin
      chk(inv_done && !inv_hit && !mem_valid, req, {inv_done, inv_hit, mem_valid}, 3'b100);
      @(negedge clk);
      inv_valid = 0;
      return;
    end
    chk(!inv_done && !mem_valid, req, {inv_done, mem_valid}, 2'b00);
    @(negedge clk); #1;
    for (int k = 0; k < delay; k++) begin
      chk(mem_valid && !inv_done && mem_addr == ea && mem_data == ed, {req, " hold"},
          {mem_valid, inv_done, mem_addr}, {1'b1, 1'b0, ea});
      @(negedge clk); #1;
    end
    mem_ready = 1; #1;
    chk(mem_valid && inv_done && inv_hit, req, {inv_done, inv_hit, mem_valid}, 3'b111);
    chk(mem_addr == ea, {req, " addr"}, mem_addr, ea);
    chk(mem_data == ed, {req, " data"}, mem_data, ed);
    @(negedge clk);
    mem_ready = 0; inv_valid = 0;
  endtask

  task automatic do_discard();
    @(negedge clk); discard = 1;
    #1 chk(!mem_valid, "R6 discard no write", mem_valid, 0);
    @(negedge clk); discard = 0;
  endtask

  task automatic t_reset();
    #1 chk(!mem_valid && !overflow && !inv_done, "reset outputs", {mem_valid, overflow, inv_done}, 3'b000);
  endtask

  task automatic t_noncache();
    do_push(32'h100, 32'hDEAD_0001, 0, 0, "R1 push");
    do_inv(32'h100, 0, 0, 0, 0, "R1 ignored non-cacheable");
  endtask

  task automatic t_order();
    do_push(32'h204, 32'hA1, 1, 0, "R2 push");
    do_push(32'h21C, 32'hA2, 1, 0, "R2 push");
    do_push(32'h300, 32'hA3, 1, 0, "R2 push");
    do_inv(32'h210, 1, 32'h204, 32'hA1, 0, "R5 oldest first");
    do_inv(32'h210, 1, 32'h21C, 32'hA2, 0, "R5 younger kept");
    do_inv(32'h210, 0, 0, 0, 0, "R9 miss after drain");
    do_inv(32'h300, 1, 32'h300, 32'hA3, 0, "R4 saved addr/data");
  endtask

  task automatic t_line();
    do_push(32'h400, 32'hB0, 1, 0, "R3 push");
    do_inv(32'h420, 0, 0, 0, 0, "R3 bit5 differs");
    do_inv(32'h41F, 1, 32'h400, 32'hB0, 0, "R3 low bits ignored");
  endtask

  task automatic t_handshake();
    do_push(32'h808, 32'hC0DE, 1, 0, "R7 push");
    do_inv(32'h800, 1, 32'h808, 32'hC0DE, 3, "R7 backpressure");
    do_inv(32'h800, 0, 0, 0, 0, "R4 single store removed");
  endtask

  task automatic t_compact();
    do_push(32'h500, 32'hD0, 1, 0, "R10 push");
    do_push(32'h600, 32'hD1, 1, 0, "R10 push");
    do_push(32'h508, 32'hD2, 1, 0, "R10 push");
    do_push(32'h700, 32'hD3, 1, 0, "R10 push");
    do_inv(32'h600, 1, 32'h600, 32'hD1, 0, "R10 middle remove");
    do_push(32'h50C, 32'hD4, 1, 0, "R10 push after compact");
    do_inv(32'h500, 1, 32'h500, 32'hD0, 0, "R10 order head");
    do_inv(32'h500, 1, 32'h508, 32'hD2, 0, "R10 order kept");
    do_inv(32'h700, 1, 32'h700, 32'hD3, 0, "R10 tail shifted");
    do_inv(32'h500, 1, 32'h50C, 32'hD4, 0, "R2 appended at tail");
  endtask

  task automatic t_discard_overflow();
    do_push(32'h900, 32'hE0, 1, 0, "R6 push");
    do_push(32'hA00, 32'hE1, 1, 0, "R6 push");
    do_push(32'hB00, 32'hE2, 1, 0, "R6 push");
    do_discard();
    do_inv(32'h900, 0, 0, 0, 0, "R6 emptied");
    do_inv(32'hB00, 0, 0, 0, 0, "R6 emptied");
    for (int i = 0; i < DEPTH; i++)
      do_push(32'h1000 + 32'(i) * 32'h40, 32'hF0 + 32'(i), 1, 0, "R6 tail reset refill");
    do_push(32'h2000, 32'hFF, 1, 1, "R8 overflow flag");
    @(negedge clk); #1 chk(!overflow, "R8 flag one cycle", overflow, 0);
    do_inv(32'h2000, 0, 0, 0, 0, "R8 dropped entry");
    for (int i = 0; i < DEPTH; i++)
      do_inv(32'h1000 + 32'(i) * 32'h40, 1, 32'h1000 + 32'(i) * 32'h40, 32'hF0 + 32'(i), 0, "R8 kept entries");
  endtask

  initial begin
    #1 t_reset();
    #45 rst_n = 1;
    t_noncache();
    t_order();
    t_line();
    t_handshake();
    t_compact();
    t_discard_overflow();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      checks++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 1, 0);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule